// File: doc/BRIEF.md
# Low Pin Count Bus Target with Local Request Port

This block is a target on the Low Pin Count host bus. It runs on the bus clock, samples the four multiplexed address/data lines and the active-low framing strobe, and decodes single-byte transfers addressed to it. I/O writes are always accepted. I/O reads, single-byte firmware reads and ordinary memory reads are accepted only when their enable inputs allow them.

When a transfer has been decoded, the block presents the captured address, the direction and any write byte on a local request port. It raises a valid strobe and holds it until the local side acknowledges. While it waits, the block answers the host with long-wait SYNC nibbles. After the acknowledge it returns a ready SYNC, then the read byte if there is one, then its own turnaround nibble, and then it releases the lines. A framing strobe driven low in the middle of a transfer abandons the transfer.

Top module: `lpc_target`

## Requirements
- R1: While `rst_n` is low, and on every idle cycle afterwards, `lad_oe` and `loc_valid` are both 0.
- R2: A cycle opens when `frame_n` is low with `lad_in` = 4'b0000 and `frame_n` then goes high. A type nibble of 4'b0010 (I/O write) is then followed by four address nibbles, most significant first. These are shown zero-extended on the 24-bit `loc_addr`.
- R3: For an I/O write, the two nibbles after the address form the data byte, low nibble first, so 4'hA then 4'h5 gives 8'h5A on `loc_wdata`. `loc_we` is 1 while `loc_valid` is high.
- R4: During the two host turnaround nibbles that follow the last address or data nibble, `lad_oe` stays 0. The first cycle the block drives is a long-wait SYNC.
- R5: In the wait phase, `lad_oe` = 1, `lad_out` = 4'h6 and `loc_valid` = 1. This holds on every cycle until `loc_ack` is sampled high.
- R6: On the clock after `loc_ack` is sampled, `loc_valid` is 0 and `lad_out` = 4'h0 with `lad_oe` = 1. A write then has one cycle of 4'hF with `lad_oe` = 1, after which `lad_oe` returns to 0.
- R7: A type nibble of 4'b0000 (I/O read) is accepted only when `rd_en` = 1 and presents `loc_we` = 0. The byte on `loc_rdata` is captured in the cycle that `loc_ack` is sampled. After the ready SYNC it is driven as its low nibble, then its high nibble, then 4'hF.
- R8: A type nibble of 4'b0100 (memory read) is accepted only when both `rd_en` and `mem_rd_en` are 1. It carries eight address nibbles, and the low 24 bits appear on `loc_addr`.
- R9: A start nibble of 4'b1101 (firmware read) is accepted when `rd_en` = 1. One select nibble, which is ignored, is followed by seven address nibbles, whose low 24 bits appear on `loc_addr`, and a size nibble. Only a size nibble of 4'b0000 is served.
- R10: A cycle that is rejected, whether for an unsupported type such as 4'b0110 (memory write), a disabled read or a firmware size other than zero, never drives `lad_oe` and never raises `loc_valid`.
- R11: If `frame_n` is low in the middle of a cycle, including the wait phase, then on the next clock `lad_oe` and `loc_valid` are 0. A following start nibble opens a new cycle normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Allows I/O reads and firmware reads |
| mem_rd_en | input | 1 | Also allows ordinary memory reads (needs rd_en) |
| frame_n | input | 1 | Active-low framing strobe from host |
| lad_in | input | 4 | Multiplexed address/data nibble from host |
| lad_out | output | 4 | Nibble driven toward host |
| lad_oe | output | 1 | Output enable for lad_out |
| loc_addr | output | 24 | Captured address for the local request |
| loc_we | output | 1 | 1 for a write request, 0 for a read request |
| loc_wdata | output | 8 | Captured write byte |
| loc_rdata | input | 8 | Read byte from local side, sampled with loc_ack |
| loc_valid | output | 1 | Local request pending |
| loc_ack | input | 1 | Local side completes the request |

## Verification
The assertions assume that the local side raises `loc_ack` only while `loc_valid` is high and removes it once `loc_valid` has fallen. They also assume that both read enables hold still for the whole of a bus cycle and that the host keeps `frame_n` high between the opening nibble and the end of the cycle, except when it aborts on purpose. The stimulus tasks drive every host nibble on the falling edge and pulse `loc_ack` for exactly one cycle after a chosen number of wait cycles. They change `rd_en` and `mem_rd_en` only between cycles, and they pull `frame_n` low mid-cycle only in the two abort scenarios.

// File: rtl/lpc_target_pkg.sv
package lpc_target_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_FWID, ST_ADDR, ST_FWSIZE, ST_WDATA,
    ST_HTAR, ST_WAIT, ST_SYNC, ST_RDATA, ST_PTAR
  } lpc_state_e;

  typedef enum logic [1:0] {
    K_IOW, K_IOR, K_MEMR, K_FWR
  } lpc_kind_e;

  localparam logic [3:0] NIB_START_STD = 4'h0;
  localparam logic [3:0] NIB_START_FW  = 4'hD;
  localparam logic [3:0] NIB_TYP_IOR   = 4'h0;
  localparam logic [3:0] NIB_TYP_IOW   = 4'h2;
  localparam logic [3:0] NIB_TYP_MEMR  = 4'h4;
  localparam logic [3:0] NIB_SZ_BYTE   = 4'h0;
  localparam logic [3:0] NIB_LWAIT     = 4'h6;
  localparam logic [3:0] NIB_READY     = 4'h0;
  localparam logic [3:0] NIB_TURN      = 4'hF;

  localparam int IO_ADDR_NIBS  = 4;
  localparam int MEM_ADDR_NIBS = 8;
  localparam int FW_ADDR_NIBS  = 7;

endpackage

// File: rtl/lpc_target_fsm.sv
module lpc_target_fsm
  import lpc_target_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  input  logic       rd_en,
  input  logic       mem_rd_en,
  input  logic       loc_ack,
  output lpc_state_e state,
  output lpc_kind_e  kind,
  output logic       clr_addr,
  output logic       shift_addr,
  output logic       cap_wlo,
  output logic       cap_whi,
  output logic       cap_rdata,
  output logic       nib_hi,
  output logic       valid
);

  localparam int CNT_W = 3;

  lpc_state_e       st_q, st_d;
  lpc_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d       = st_q;
    kind_d     = kind_q;
    cnt_d      = cnt_q;
    clr_addr   = 1'b0;
    shift_addr = 1'b0;
    cap_wlo    = 1'b0;
    cap_whi    = 1'b0;
    cap_rdata  = 1'b0;
    if (!frame_n) begin
      if (lad_in == NIB_START_STD) begin
        st_d = ST_CTYPE;
      end else if (lad_in == NIB_START_FW && rd_en) begin
        st_d   = ST_FWID;
        kind_d = K_FWR;
      end else begin
        st_d = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_CTYPE: begin
          clr_addr = 1'b1;
          st_d     = ST_ADDR;
          cnt_d    = CNT_W'(IO_ADDR_NIBS - 1);
          if (lad_in == NIB_TYP_IOW) begin
            kind_d = K_IOW;
          end else if (lad_in == NIB_TYP_IOR && rd_en) begin
            kind_d = K_IOR;
          end else if (lad_in == NIB_TYP_MEMR && rd_en && mem_rd_en) begin
            kind_d = K_MEMR;
            cnt_d  = CNT_W'(MEM_ADDR_NIBS - 1);
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_FWID: begin
          clr_addr = 1'b1;
          st_d     = ST_ADDR;
          cnt_d    = CNT_W'(FW_ADDR_NIBS - 1);
        end
        ST_ADDR: begin
          shift_addr = 1'b1;
          cnt_d      = cnt_q - 1'b1;
          if (cnt_q == '0) begin
            cnt_d = CNT_W'(1);
            if (kind_q == K_IOW)      st_d = ST_WDATA;
            else if (kind_q == K_FWR) st_d = ST_FWSIZE;
            else                      st_d = ST_HTAR;
          end
        end
        ST_FWSIZE: begin
          cnt_d = CNT_W'(1);
          st_d  = (lad_in == NIB_SZ_BYTE) ? ST_HTAR : ST_IDLE;
        end
        ST_WDATA: begin
          cap_wlo = cnt_q[0];
          cap_whi = ~cnt_q[0];
          cnt_d   = cnt_q - 1'b1;
          if (cnt_q == '0) begin
            cnt_d = CNT_W'(1);
            st_d  = ST_HTAR;
          end
        end
        ST_HTAR: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == '0) st_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (loc_ack) begin
            cap_rdata = 1'b1;
            st_d      = ST_SYNC;
          end
        end
        ST_SYNC: begin
          cnt_d = CNT_W'(1);
          st_d  = (kind_q == K_IOW) ? ST_PTAR : ST_RDATA;
        end
        ST_RDATA: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == '0) st_d = ST_PTAR;
        end
        ST_PTAR: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_IOW;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
    end
  end

  assign state  = st_q;
  assign kind   = kind_q;
  assign nib_hi = (cnt_q == '0);
  assign valid  = (st_q == ST_WAIT);

  // R5: a pending request is never withdrawn before the acknowledge
  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !loc_ack && frame_n |=> valid);

  // R6: the acknowledge always ends the request on the next clock
  assert_ack_ends_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && loc_ack && frame_n |=> !valid && state == ST_SYNC);

endmodule

// File: rtl/lpc_target_datapath.sv
module lpc_target_datapath #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        lad_in,
  input  logic              clr_addr,
  input  logic              shift_addr,
  input  logic              cap_wlo,
  input  logic              cap_whi,
  input  logic              cap_rdata,
  input  logic              nib_hi,
  input  logic [7:0]        loc_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic [3:0]        rd_nib
);

  localparam int NIB_W = 4;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic [7:0]        rdata_q, rdata_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (clr_addr)        addr_d = '0;
    else if (shift_addr) addr_d = {addr_q[ADDR_W-NIB_W-1:0], lad_in};
    if (cap_wlo) wdata_d[3:0] = lad_in;
    if (cap_whi) wdata_d[7:4] = lad_in;
    if (cap_rdata) rdata_d = loc_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign addr   = addr_q;
  assign wdata  = wdata_q;
  assign rd_nib = nib_hi ? rdata_q[7:4] : rdata_q[3:0];

endmodule

// File: rtl/lpc_target.sv
module lpc_target
  import lpc_target_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              mem_rd_en,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic [ADDR_W-1:0] loc_addr,
  output logic              loc_we,
  output logic [7:0]        loc_wdata,
  input  logic [7:0]        loc_rdata,
  output logic              loc_valid,
  input  logic              loc_ack
);

  lpc_state_e state;
  lpc_kind_e  kind;
  logic       clr_addr, shift_addr, cap_wlo, cap_whi, cap_rdata, nib_hi;
  logic [3:0] rd_nib;

  lpc_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .rd_en(rd_en), .mem_rd_en(mem_rd_en), .loc_ack(loc_ack),
    .state(state), .kind(kind), .clr_addr(clr_addr), .shift_addr(shift_addr),
    .cap_wlo(cap_wlo), .cap_whi(cap_whi), .cap_rdata(cap_rdata),
    .nib_hi(nib_hi), .valid(loc_valid)
  );

  lpc_target_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .lad_in(lad_in),
    .clr_addr(clr_addr), .shift_addr(shift_addr),
    .cap_wlo(cap_wlo), .cap_whi(cap_whi), .cap_rdata(cap_rdata),
    .nib_hi(nib_hi), .loc_rdata(loc_rdata),
    .addr(loc_addr), .wdata(loc_wdata), .rd_nib(rd_nib)
  );

  always_comb begin
    lad_oe  = 1'b1;
    lad_out = NIB_TURN;
    case (state)
      ST_WAIT:  lad_out = NIB_LWAIT;
      ST_SYNC:  lad_out = NIB_READY;
      ST_RDATA: lad_out = rd_nib;
      ST_PTAR:  lad_out = NIB_TURN;
      default:  lad_oe  = 1'b0;
    endcase
  end

  assign loc_we = (kind == K_IOW);

  // R4: driving always begins with a long-wait nibble and a pending request
  assert_drive_starts_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h6 && loc_valid);

  // R6: ready SYNC follows the acknowledge
  assert_ready_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid && loc_ack && frame_n |=> lad_oe && lad_out == 4'h0);

  // R11: a low framing strobe releases the lines and drops the request
  assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe && !loc_valid);

  // R2, R3: the request is stable while it is pending
  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid && $past(loc_valid) |-> $stable(loc_addr) && $stable(loc_we) && $stable(loc_wdata));

endmodule

// File: tb/lpc_target_test.sv
module lpc_target_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        mem_rd_en = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [7:0]  loc_rdata = 8'h00;
  logic        loc_ack = 1'b0;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [23:0] loc_addr;
  logic        loc_we;
  logic [7:0]  loc_wdata;
  logic        loc_valid;

  always #4 clk = ~clk;

  lpc_target uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mem_rd_en(mem_rd_en),
    .frame_n(frame_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_valid(loc_valid), .loc_ack(loc_ack)
  );

  typedef struct {
    bit          valid;
    bit          oe;
    logic [3:0]  lad;
    bit          chk_req;
    bit          we;
    logic [23:0] addr;
    logic [7:0]  wdata;
    string       req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic push(bit v, bit oe, logic [3:0] l, string req);
    exp_t e;
    e.valid = v; e.oe = oe; e.lad = l; e.chk_req = 1'b0;
    e.we = 1'b0; e.addr = '0; e.wdata = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_req(bit we, logic [23:0] a, logic [7:0] d, string req);
    exp_t e;
    e.valid = 1'b1; e.oe = 1'b1; e.lad = 4'h6; e.chk_req = 1'b1;
    e.we = we; e.addr = a; e.wdata = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic drv(bit f, logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    lad_in  = n;
  endtask

  // reference comparison every clock, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      begin
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else begin
          e.valid = 1'b0; e.oe = 1'b0; e.lad = 4'hF; e.chk_req = 1'b0;
          e.we = 1'b0; e.addr = '0; e.wdata = '0; e.req = "R1";
        end
        chk(e.req, "lad_oe", int'(lad_oe), int'(e.oe));
        chk(e.req, "loc_valid", int'(loc_valid), int'(e.valid));
        if (e.oe) chk(e.req, "lad_out", int'(lad_out), int'(e.lad));
        if (e.chk_req) begin
          chk(e.req, "loc_we", int'(loc_we), int'(e.we));
          chk(e.req, "loc_addr", int'(loc_addr), int'(e.addr));
          if (e.we) chk(e.req, "loc_wdata", int'(loc_wdata), int'(e.wdata));
        end
      end
    end
  end

  // kind: 0 I/O write, 1 I/O read, 2 memory read, 3 firmware read, 4 memory write
  task automatic bus_cycle(int kind, logic [31:0] addr, logic [7:0] wd, logic [7:0] rd,
                           int waits, bit accept, logic [3:0] fwsize, bit abort_wait,
                           string req);
    int nad;
    logic [3:0] typ;
    logic [23:0] ea;
    string r_idle;
    r_idle = accept ? "R4" : "R10";
    drv(1'b0, kind == 3 ? 4'hD : 4'h0); push(1'b0, 1'b0, 4'h0, r_idle);
    case (kind)
      0: begin typ = 4'h2; nad = 4; end
      1: begin typ = 4'h0; nad = 4; end
      2: begin typ = 4'h4; nad = 8; end
      3: begin typ = 4'h3; nad = 7; end
      default: begin typ = 4'h6; nad = 8; end
    endcase
    drv(1'b1, typ); push(1'b0, 1'b0, 4'h0, r_idle);
    for (int i = 0; i < nad; i++) begin
      drv(1'b1, addr[4*(nad-1-i) +: 4]); push(1'b0, 1'b0, 4'h0, r_idle);
    end
    if (kind == 3) begin drv(1'b1, fwsize); push(1'b0, 1'b0, 4'h0, r_idle); end
    if (kind == 0 || kind == 4) begin
      drv(1'b1, wd[3:0]); push(1'b0, 1'b0, 4'h0, r_idle);
      drv(1'b1, wd[7:4]); push(1'b0, 1'b0, 4'h0, r_idle);
    end
    drv(1'b1, 4'hF); push(1'b0, 1'b0, 4'h0, r_idle);
    drv(1'b1, 4'hF);
    if (!accept) begin
      push(1'b0, 1'b0, 4'h0, "R10");
      return;
    end
    ea = (kind <= 1) ? {8'h00, addr[15:0]} : addr[23:0];
    push_req(kind == 0, ea, wd, req);
    for (int w = 1; w < waits; w++) begin
      drv(1'b1, 4'hF); push_req(kind == 0, ea, wd, "R5");
    end
    if (abort_wait) begin
      drv(1'b0, 4'hF); push(1'b0, 1'b0, 4'h0, "R11");
      drv(1'b1, 4'hF); push(1'b0, 1'b0, 4'h0, "R11");
      return;
    end
    @(negedge clk); loc_ack = 1'b1; loc_rdata = rd; push(1'b0, 1'b1, 4'h0, "R6");
    @(negedge clk); loc_ack = 1'b0; loc_rdata = ~rd;
    if (kind != 0) begin
      push(1'b0, 1'b1, rd[3:0], "R7");
      @(negedge clk); push(1'b0, 1'b1, rd[7:4], "R7");
      @(negedge clk);
    end
    push(1'b0, 1'b1, 4'hF, "R6");
    @(negedge clk); push(1'b0, 1'b0, 4'h0, "R6");
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin drv(1'b1, 4'hF); push(1'b0, 1'b0, 4'h0, "R1"); end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    gap(2);
    // R2 R3: I/O write, data A then 5 gives 5A
    bus_cycle(0, 32'h0080, 8'h5A, 8'h00, 3, 1'b1, 4'h0, 1'b0, "R2");
    gap(2);
    bus_cycle(0, 32'hBEEF, 8'hC3, 8'h00, 1, 1'b1, 4'h0, 1'b0, "R3");
    gap(1);
    // R7: I/O read enabled and disabled
    rd_en = 1'b1;
    bus_cycle(1, 32'h1234, 8'h00, 8'hA7, 2, 1'b1, 4'h0, 1'b0, "R7");
    gap(1);
    rd_en = 1'b0;
    bus_cycle(1, 32'h4321, 8'h00, 8'h11, 1, 1'b0, 4'h0, 1'b0, "R7");
    gap(1);
    // R8: memory read needs both enables
    rd_en = 1'b1; mem_rd_en = 1'b0;
    bus_cycle(2, 32'h89ABCDEF, 8'h00, 8'h22, 1, 1'b0, 4'h0, 1'b0, "R8");
    gap(1);
    mem_rd_en = 1'b1;
    bus_cycle(2, 32'h89ABCDEF, 8'h00, 8'h3C, 4, 1'b1, 4'h0, 1'b0, "R8");
    gap(1);
    // R9: firmware read, size zero served, other size rejected
    bus_cycle(3, 32'h07654321, 8'h00, 8'h96, 2, 1'b1, 4'h0, 1'b0, "R9");
    gap(1);
    bus_cycle(3, 32'h07654321, 8'h00, 8'h55, 1, 1'b0, 4'h1, 1'b0, "R9");
    gap(1);
    // R10: memory write type unsupported; firmware read with reads off
    bus_cycle(4, 32'h00001000, 8'h77, 8'h00, 1, 1'b0, 4'h0, 1'b0, "R10");
    gap(1);
    rd_en = 1'b0; mem_rd_en = 1'b0;
    bus_cycle(3, 32'h01111111, 8'h00, 8'h00, 1, 1'b0, 4'h0, 1'b0, "R10");
    gap(1);
    // R11: abort in the address phase, then a clean write
    drv(1'b0, 4'h0); push(1'b0, 1'b0, 4'h0, "R11");
    drv(1'b1, 4'h2); push(1'b0, 1'b0, 4'h0, "R11");
    drv(1'b1, 4'h1); push(1'b0, 1'b0, 4'h0, "R11");
    drv(1'b0, 4'hF); push(1'b0, 1'b0, 4'h0, "R11");
    drv(1'b1, 4'hF); push(1'b0, 1'b0, 4'h0, "R11");
    bus_cycle(0, 32'h03F8, 8'h81, 8'h00, 2, 1'b1, 4'h0, 1'b0, "R11");
    gap(1);
    // R11: abort during the wait phase, then a clean write
    bus_cycle(0, 32'h0060, 8'h42, 8'h00, 3, 1'b1, 4'h0, 1'b1, "R11");
    bus_cycle(0, 32'h0064, 8'hE1, 8'h00, 1, 1'b1, 4'h0, 1'b0, "R5");
    gap(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule